// File: doc/BRIEF.md
# Aging-Based Traffic Imbalance Alert Controller

This controller sits between a processing element and its network interface and runs a sensor that detects snooping traffic by aging a transistor on purpose. It holds the selected stress transistor in stress while incoming messages outnumber the replies, and lets it recover when an outgoing message leaves. A node that receives far more than it sends ages its sensor faster. The sensor output then switches sooner than it would under normal traffic.

The controller times each sensing interval with a slow, prescaled counter. When the sensor output rises, it compares the elapsed count with a threshold set by trusted firmware and raises a sticky alert if the rise came early. Every sensor output change also ages the active device, so the controller raises its drive-level code by one step of about 100 mV on each change. When that code is already at its top value, the controller moves to the next of three spare transistors. After the last transistor is used up it reports end of life and stops measuring.

Top module: `aging_alert_ctrl`

## Requirements
- R1: A cycle with `msg_in` high sets `stress_on` to 1 on the next clock edge, even if `msg_out` is also high. A cycle with only `msg_out` high clears it to 0. With neither input high, `stress_on` keeps its value.
- R2: `xtor_sel` is one-hot across three bits, and bit i selects transistor i. Reset selects transistor 0 (3'b001).
- R3: While the sensor input is low, `meas_cnt` advances by one every PRESCALE (4) clock cycles. Counted from the release of reset with the sensor low, after n edges it reads floor(n/4).
- R4: `meas_cnt` stops at 255 and never wraps to zero.
- R5: On a low-to-high sensor transition, `alert` is set when the count held before that edge is strictly below `thresh`. A count equal to the threshold does not alert. `meas_cnt` reads 0 after that edge.
- R6: `alert` stays set until `alert_clr` is high. If a new alert and a clear arrive in the same cycle, the alert wins.
- R7: Each sensor transition, rising or falling, raises `drive_code` by one.
- R8: A transition that arrives while `drive_code` is 5 (the top valid level) moves `xtor_sel` to the next transistor and resets `drive_code` to 0.
- R9: A transition that arrives with transistor 2 selected and `drive_code` at 5 sets `eol`. From then on, `meas_cnt` stays 0, sensor rises raise no alert, and `drive_code` and `xtor_sel` no longer change.
- R10: Synchronous active-low reset gives `stress_on`=0, `xtor_sel`=3'b001, `drive_code`=0, `meas_cnt`=0, `alert`=0 and `eol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_in | input | 1 | Incoming message observed this cycle |
| msg_out | input | 1 | Outgoing message observed this cycle |
| sense_in | input | 1 | Sensor output, synchronous to clk |
| thresh | input | 8 | Firmware threshold in prescaled ticks |
| alert_clr | input | 1 | Clears the alert flag |
| stress_on | output | 1 | 1 = stress, 0 = recovery for the selected transistor |
| xtor_sel | output | 3 | One-hot stress transistor select |
| drive_code | output | 3 | Drive-level code for the active transistor |
| meas_cnt | output | 8 | Elapsed ticks of the current interval |
| alert | output | 1 | Early-switch alert, sticky |
| eol | output | 1 | All stress transistors exhausted |

## Verification
Each result is registered once, so stress state, alert, drive code, select, counter clear and end of life all show one clock edge after the input cycle that caused them. The bench drives inputs on the falling edge and samples on the next falling edge, which puts exactly one rising edge between stimulus and check. Counter checks after reset count rising edges to predict floor(n/4) exactly. The threshold boundary reads `meas_cnt` in the same falling-edge slot where it raises the sensor, so the compared value is known regardless of prescaler phase.

// File: rtl/aac_pkg.sv
// Package: shared types for the aging alert controller.
// Assumes: nothing beyond standard SystemVerilog.
package aac_pkg;

    // Drive mode applied to the selected stress transistor
    typedef enum logic {
        DRV_RELAX  = 1'b0,
        DRV_STRESS = 1'b1
    } drive_mode_e;

endpackage

// File: rtl/aac_tick_gen.sv
// Module: aac_tick_gen
// Emits a one-cycle tick every PRESCALE cycles while run is high.
// Assumes: the phase restarts whenever run drops, so every interval
// begins with a full prescale period.
module aac_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);

    logic [PC_W-1:0] pc_q;

    // Prescale phase counter, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run || pc_q == PC_LAST) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    assign tick = run && (pc_q == PC_LAST);

endmodule

// File: rtl/aac_interval_timer.sv
// Module: aac_interval_timer
// Counts prescaled ticks over a sensing interval, saturating at the top
// value, and raises a sticky alert when an interval ends early.
// Assumes: meas marks the cycle in which an interval ends, and clear
// is asserted whenever the interval must restart from zero.
module aac_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             meas,
    input  logic [CNT_W-1:0] thresh,
    input  logic             alert_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             alert
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             alert_q;
    logic             early;

    assign early = meas && (cnt_q < thresh);

    // Saturating interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky alert; a new early event beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else if (early) begin
            alert_q <= 1'b1;
        end else if (alert_clr) begin
            alert_q <= 1'b0;
        end
    end

    assign cnt   = cnt_q;
    assign alert = alert_q;

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX));

    a_r6_alert_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_q && !alert_clr) |=> alert_q);

    a_r5_clear_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
        meas |=> (cnt_q == '0));

endmodule

// File: rtl/aac_drive_rotator.sv
// Module: aac_drive_rotator
// Steps the drive-level code on every sensor change and rotates to the
// next spare stress transistor once the code is at its top level; flags
// end of life after the last one.
// Assumes: MAX_LVL fits in LVL_W bits and NUM_XTOR >= 1.
module aac_drive_rotator #(
    parameter int NUM_XTOR = 3,
    parameter int LVL_W    = 3,
    parameter int MAX_LVL  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [NUM_XTOR-1:0] sel,
    output logic [LVL_W-1:0]    code,
    output logic                eol
);
    localparam int IDX_W = (NUM_XTOR > 1) ? $clog2(NUM_XTOR) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_XTOR - 1);
    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(MAX_LVL);

    logic [IDX_W-1:0] idx_q;
    logic [LVL_W-1:0] code_q;
    logic             eol_q;

    // Level stepping, transistor rotation and end-of-life latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            code_q <= '0;
            eol_q  <= 1'b0;
        end else if (step && !eol_q) begin
            if (code_q != LVL_TOP) begin
                code_q <= code_q + 1'b1;
            end else if (idx_q != IDX_LAST) begin
                idx_q  <= idx_q + 1'b1;
                code_q <= '0;
            end else begin
                eol_q  <= 1'b1;
            end
        end
    end

    // One-hot decode of the active transistor index
    for (genvar g = 0; g < NUM_XTOR; g++) begin : g_sel
        assign sel[g] = (idx_q == IDX_W'(g));
    end

    assign code = code_q;
    assign eol  = eol_q;

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel));

    a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= LVL_TOP);

    a_r9_eol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eol_q |=> eol_q);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        eol_q |=> ($stable(code_q) && $stable(idx_q)));

    a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !eol_q && code_q != LVL_TOP) |=> (code_q == $past(code_q) + 1'b1));

endmodule

// File: rtl/aging_alert_ctrl.sv
// Module: aging_alert_ctrl (top)
// Digital controller for an aging-based snooping detector: drives the
// stress/recovery mode, detects sensor edges, times intervals, raises
// early-switch alerts and manages drive level and spare rotation.
// Assumes: sense_in is already synchronous to clk; thresh is static
// around a measurement.
module aging_alert_ctrl #(
    parameter int NUM_XTOR = 3,
    parameter int LVL_W    = 3,
    parameter int MAX_LVL  = 5,
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_in,
    input  logic                msg_out,
    input  logic                sense_in,
    input  logic [CNT_W-1:0]    thresh,
    input  logic                alert_clr,
    output logic                stress_on,
    output logic [NUM_XTOR-1:0] xtor_sel,
    output logic [LVL_W-1:0]    drive_code,
    output logic [CNT_W-1:0]    meas_cnt,
    output logic                alert,
    output logic                eol
);
    import aac_pkg::*;

    drive_mode_e mode_q;
    logic        sense_q;
    logic        rise;
    logic        fall;
    logic        run;
    logic        tick;
    logic        eol_w;

    // Stress/recovery mode; incoming traffic has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= DRV_RELAX;
        end else if (msg_in) begin
            mode_q <= DRV_STRESS;
        end else if (msg_out) begin
            mode_q <= DRV_RELAX;
        end
    end

    // Previous sensor level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= 1'b0;
        end else begin
            sense_q <= sense_in;
        end
    end

    assign rise = sense_in && !sense_q;
    assign fall = !sense_in && sense_q;
    assign run  = !sense_q && !rise && !eol_w;

    aac_tick_gen #(
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    aac_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clear     (rise || eol_w),
        .meas      (rise && !eol_w),
        .thresh    (thresh),
        .alert_clr (alert_clr),
        .cnt       (meas_cnt),
        .alert     (alert)
    );

    aac_drive_rotator #(
        .NUM_XTOR (NUM_XTOR),
        .LVL_W    (LVL_W),
        .MAX_LVL  (MAX_LVL)
    ) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rise || fall),
        .sel   (xtor_sel),
        .code  (drive_code),
        .eol   (eol_w)
    );

    assign stress_on = (mode_q == DRV_STRESS);
    assign eol       = eol_w;

    a_r1_stress_priority: assert property (@(posedge clk) disable iff (!rst_n)
        msg_in |=> stress_on);

    a_r1_relax: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_out && !msg_in) |=> !stress_on);

    a_r9_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eol_w |=> (meas_cnt == '0));

    a_r9_no_new_alert: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_w && !alert) |=> !alert);

endmodule

// File: tb/aging_alert_ctrl_bench.sv
// Directed bench for aging_alert_ctrl; each task checks its own results.
module aging_alert_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_in = 1'b0;
    logic       msg_out = 1'b0;
    logic       sense_in = 1'b0;
    logic [7:0] thresh = 8'd0;
    logic       alert_clr = 1'b0;
    logic       stress_on;
    logic [2:0] xtor_sel;
    logic [2:0] drive_code;
    logic [7:0] meas_cnt;
    logic       alert;
    logic       eol;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of level/select/end-of-life
    int m_code = 0;
    int m_idx  = 0;
    bit m_eol  = 1'b0;

    always #10 clk = ~clk;

    aging_alert_ctrl u_aging_alert_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_in     (msg_in),
        .msg_out    (msg_out),
        .sense_in   (sense_in),
        .thresh     (thresh),
        .alert_clr  (alert_clr),
        .stress_on  (stress_on),
        .xtor_sel   (xtor_sel),
        .drive_code (drive_code),
        .meas_cnt   (meas_cnt),
        .alert      (alert),
        .eol        (eol)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step1();
        @(negedge clk);
    endtask

    // Sensor transition plus model update and level/select check
    task automatic sense_edge(input logic val, input string req);
        sense_in = val;
        step1();
        if (!m_eol) begin
            if (m_code < 5) m_code++;
            else if (m_idx < 2) begin m_idx++; m_code = 0; end
            else m_eol = 1'b1;
        end
        chk({req, " drive_code"}, int'(drive_code), m_code);
        chk({req, " xtor_sel"}, int'(xtor_sel), 1 << m_idx);
        chk({req, " eol"}, int'(eol), int'(m_eol));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step1();
        chk("R10 stress_on", int'(stress_on), 0);
        chk("R10 xtor_sel", int'(xtor_sel), 1);
        chk("R10 drive_code", int'(drive_code), 0);
        chk("R10 meas_cnt", int'(meas_cnt), 0);
        chk("R10 alert", int'(alert), 0);
        chk("R10 eol", int'(eol), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        repeat (10) step1();
        chk("R3 count after 10", int'(meas_cnt), 2);
        repeat (7) step1();
        chk("R3 count after 17", int'(meas_cnt), 4);
    endtask

    task automatic t_stress();
        msg_in = 1'b1; step1(); msg_in = 1'b0;
        chk("R1 stress on in", int'(stress_on), 1);
        msg_out = 1'b1; step1(); msg_out = 1'b0;
        chk("R1 relax on out", int'(stress_on), 0);
        msg_in = 1'b1; msg_out = 1'b1; step1(); msg_in = 1'b0; msg_out = 1'b0;
        chk("R1 both gives stress", int'(stress_on), 1);
        repeat (2) step1();
        chk("R1 hold", int'(stress_on), 1);
        msg_out = 1'b1; step1(); msg_out = 1'b0;
        chk("R1 relax again", int'(stress_on), 0);
    endtask

    task automatic t_threshold();
        int c;
        repeat (12) step1();
        c = int'(meas_cnt);
        thresh = 8'(c);
        sense_edge(1'b1, "R7 rise");
        chk("R5 equal no alert", int'(alert), 0);
        chk("R5 cleared", int'(meas_cnt), 0);
        sense_edge(1'b0, "R7 fall");
        repeat (9) step1();
        c = int'(meas_cnt);
        thresh = 8'(c + 1);
        sense_edge(1'b1, "R7 rise2");
        chk("R5 below alert", int'(alert), 1);
    endtask

    task automatic t_alert();
        int c;
        alert_clr = 1'b1; step1(); alert_clr = 1'b0;
        chk("R6 cleared", int'(alert), 0);
        sense_edge(1'b0, "R7 fall2");
        repeat (5) step1();
        c = int'(meas_cnt);
        thresh = 8'(c + 1);
        alert_clr = 1'b1;
        sense_edge(1'b1, "R7 rise3");
        alert_clr = 1'b0;
        chk("R6 set beats clear", int'(alert), 1);
        repeat (3) step1();
        chk("R6 sticky", int'(alert), 1);
        alert_clr = 1'b1; step1(); alert_clr = 1'b0;
        chk("R6 cleared again", int'(alert), 0);
        sense_edge(1'b0, "R8 rotate to 1");
    endtask

    task automatic t_saturate();
        repeat (255 * 4 + 40) step1();
        chk("R4 saturated", int'(meas_cnt), 255);
        repeat (20) step1();
        chk("R4 no wrap", int'(meas_cnt), 255);
        thresh = 8'd0;
        sense_edge(1'b1, "R7 rise4");
        chk("R5 no alert at zero thr", int'(alert), 0);
        chk("R5 cleared after sat", int'(meas_cnt), 0);
    endtask

    task automatic t_rotate();
        logic v;
        v = 1'b0;
        while (!m_eol) begin
            sense_edge(v, "R8 rotate");
            v = ~v;
        end
        chk("R9 eol", int'(eol), 1);
        alert_clr = 1'b1; step1(); alert_clr = 1'b0;
        sense_in = 1'b0;
        repeat (20) step1();
        chk("R9 count held", int'(meas_cnt), 0);
        thresh = 8'd255;
        sense_in = 1'b1; step1();
        chk("R9 no alert", int'(alert), 0);
        chk("R9 code frozen", int'(drive_code), 5);
        chk("R9 sel frozen", int'(xtor_sel), 4);
    endtask

    initial begin
        t_reset();
        t_count();
        t_stress();
        t_threshold();
        t_alert();
        t_saturate();
        t_rotate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule